// File: doc/BRIEF.md
# Variable-Width Stack Transfer Engine

This block moves a register value of one to eight bytes between a processor core and a byte-wide stack memory, one byte per clock. It owns the stack pointer (16 bits) and a stack bank register (8 bits). The two together give every stack memory address, with the bank sitting above the pointer. A command carries a direction (push or pull), a 64-bit value and a size operand. The engine clamps the size to a byte count and then steps through the bytes. It drives one write or one read strobe per busy cycle and moves the pointer after each byte.

A push stores the highest selected byte first and works down to byte 0, lowering the pointer after each write. A pull raises the pointer first and then reads, filling the result from byte 0 upward. When the last byte of a pull lands, the engine presents the assembled value with a one-cycle done strobe. The pointer and bank can be loaded through a separate configuration port while the engine is idle. Choosing the register and decoding instructions belong to the surrounding core.

Top module: `stack_xfer_engine`

## Requirements
- R1: Every stack access presents mem_addr = {bank, pointer}, i.e. bank shifted left by 16 plus the 16-bit pointer value used for that byte.
- R2: The byte count is the size operand clamped to 1..8: a size of 0 or 1 moves one byte, 2..7 move that many, and 8 or more move eight.
- R3: A push of N bytes writes byte N-1 of cmd_data (bits 8*(N-1)+7 : 8*(N-1)) first, then the next lower byte, down to byte 0, at the current pointer, and lowers the pointer by one after each write.
- R4: A pull first raises the pointer by one and reads at the raised pointer, placing the first byte read in bits 7:0 of the result, the next in bits 15:8, and so on.
- R5: Bytes of pull_data above the transferred count are zero, and pull_data together with pull_done (high for exactly one cycle) appears in the first cycle after the final read.
- R6: The pointer wraps modulo 2^16 in both directions, and a transfer never changes the bank register.
- R7: A command is accepted only while busy is low. busy then stays high for exactly N cycles, one per byte, with exactly one of mem_we or mem_re high in each of them. A command offered while busy is ignored, and no strobe is driven while idle.
- R8: When cfg_we is high while idle, the pointer and bank take cfg_sp and cfg_bank at the next edge. While busy, cfg_we is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; pointer and bank clear to 0 |
| cmd_valid | input | 1 | Offers a command; taken when busy is low |
| cmd_pull | input | 1 | 0 = push, 1 = pull |
| cmd_size | input | 8 | Size operand, clamped to a count of 1..8 |
| cmd_data | input | 64 | Value to push (ignored for a pull) |
| busy | output | 1 | High while a transfer is in progress |
| cfg_we | input | 1 | Loads pointer and bank when idle |
| cfg_sp | input | 16 | Pointer value to load |
| cfg_bank | input | 8 | Bank value to load |
| sp | output | 16 | Current stack pointer |
| bank | output | 8 | Current stack bank |
| mem_addr | output | 24 | Stack memory byte address |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe; mem_rdata is sampled at the end of the same cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read from memory, combinational with mem_addr |
| pull_data | output | 64 | Assembled pull result, held until the next pull completes |
| pull_done | output | 1 | One-cycle strobe when a pull result is ready |

## Verification
A wrong byte index shows up on mem_wdata in the very first write cycle of a push. A wrong count shows up as busy staying high too long or falling too early, and the mismatch is visible at the cycle busy falls. A pointer off by one is seen on mem_addr in the next access, and on sp as soon as the command ends. A stale assembly register shows up as nonzero upper bytes in pull_data, in the cycle pull_done rises after a short pull.

// File: rtl/stkx_pkg.sv
package stkx_pkg;

  typedef enum logic {
    DIR_PUSH = 1'b0,
    DIR_PULL = 1'b1
  } stk_dir_e;

  // Size operand to byte count: 0 and 1 give one byte, values at or above
  // the maximum give the maximum.
  function automatic int unsigned clamp_count(input int unsigned size,
                                              input int unsigned max_bytes);
    if (size <= 1) return 1;
    if (size >= max_bytes) return max_bytes;
    return size;
  endfunction

endpackage

// File: rtl/stkx_ptr_regs.sv
module stkx_ptr_regs #(
  parameter int SP_W   = 16,
  parameter int BANK_W = 8,
  localparam int ADDR_W = SP_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [SP_W-1:0]   cfg_sp,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic              step_dn,
  input  logic              step_up,
  input  logic              busy,
  output logic [SP_W-1:0]   sp_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] addr_cur,
  output logic [ADDR_W-1:0] addr_next
);

  function automatic logic [SP_W-1:0] ptr_inc(input logic [SP_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [SP_W-1:0] ptr_dec(input logic [SP_W-1:0] p);
    return p - 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] form_addr(input logic [BANK_W-1:0] b,
                                                  input logic [SP_W-1:0] p);
    return {b, p};
  endfunction

  logic [SP_W-1:0] sp_up;

  assign sp_up     = ptr_inc(sp_q);
  assign addr_cur  = form_addr(bank_q, sp_q);
  assign addr_next = form_addr(bank_q, sp_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '0;
      bank_q <= '0;
    end else if (cfg_load) begin
      sp_q   <= cfg_sp;
      bank_q <= cfg_bank;
    end else if (step_dn) begin
      sp_q <= ptr_dec(sp_q);
    end else if (step_up) begin
      sp_q <= sp_up;
    end
  end

  // R6: a transfer never touches the bank
  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bank_q == $past(bank_q));

  // R8: a load never coincides with a byte step
  assert_cfg_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> !(step_dn || step_up));

endmodule

// File: rtl/stkx_seq.sv
module stkx_seq #(
  parameter int SIZE_W    = 8,
  parameter int MAX_BYTES = 8,
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cmd_pull,
  input  logic [SIZE_W-1:0] cmd_size,
  output logic              busy,
  output logic              is_pull,
  output logic [IDX_W-1:0]  byte_idx,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic              last_byte,
  output logic              done
);
  import stkx_pkg::*;

  logic [CNT_W-1:0] left_q;
  logic [IDX_W-1:0] idx_q;
  stk_dir_e         dir_q;
  logic             done_q;
  logic [CNT_W-1:0] count_new;
  int unsigned      count_int;

  always_comb begin
    count_int = clamp_count(int'(cmd_size), MAX_BYTES);
    count_new = CNT_W'(count_int);
  end

  assign busy      = (left_q != '0);
  assign is_pull   = (dir_q == DIR_PULL);
  assign byte_idx  = idx_q;
  assign wr_stb    = busy && !is_pull;
  assign rd_stb    = busy && is_pull;
  assign last_byte = (left_q == CNT_W'(1));
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      idx_q  <= '0;
      dir_q  <= DIR_PUSH;
      done_q <= 1'b0;
    end else begin
      done_q <= rd_stb && last_byte;
      if (accept) begin
        left_q <= count_new;
        dir_q  <= cmd_pull ? DIR_PULL : DIR_PUSH;
        idx_q  <= cmd_pull ? '0 : IDX_W'(count_int - 1);
      end else if (busy) begin
        left_q <= left_q - 1'b1;
        idx_q  <= is_pull ? idx_q + 1'b1 : idx_q - 1'b1;
      end
    end
  end

  // R2: an accepted command always loads a count inside 1..MAX_BYTES
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (left_q >= CNT_W'(1)) && (left_q <= CNT_W'(MAX_BYTES)));

  // R7: no command is taken while a transfer runs
  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R5: the done strobe is a single cycle and comes after the engine idles
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/stkx_pack.sv
module stkx_pack #(
  parameter int MAX_BYTES = 8,
  localparam int DATA_W = 8 * MAX_BYTES,
  localparam int IDX_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cmd_pull,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic              rd_stb,
  input  logic              last_byte,
  input  logic [7:0]        rd_byte,
  output logic [7:0]        wr_byte,
  output logic [DATA_W-1:0] result
);

  function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] d,
                                           input logic [IDX_W-1:0] i);
    return d[int'(i)*8 +: 8];
  endfunction

  function automatic logic [DATA_W-1:0] put_byte(input logic [DATA_W-1:0] d,
                                                 input logic [IDX_W-1:0] i,
                                                 input logic [7:0] b);
    logic [DATA_W-1:0] r;
    r = d;
    r[int'(i)*8 +: 8] = b;
    return r;
  endfunction

  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] result_q;
  logic [DATA_W-1:0] merged;

  assign wr_byte = pick_byte(src_q, byte_idx);
  assign merged  = put_byte(shadow_q, byte_idx, rd_byte);
  assign result  = result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      shadow_q <= '0;
      result_q <= '0;
    end else begin
      if (accept) begin
        src_q <= cmd_pull ? '0 : cmd_data;
        if (cmd_pull) shadow_q <= '0;
      end else if (rd_stb) begin
        shadow_q <= merged;
        if (last_byte) result_q <= merged;
      end
    end
  end

  // R5: a fresh pull starts from an all-zero assembly
  assert_shadow_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_pull) |=> shadow_q == '0);

endmodule

// File: rtl/stack_xfer_engine.sv
module stack_xfer_engine #(
  parameter int SP_W      = 16,
  parameter int BANK_W    = 8,
  parameter int SIZE_W    = 8,
  parameter int MAX_BYTES = 8,
  localparam int ADDR_W = SP_W + BANK_W,
  localparam int DATA_W = 8 * MAX_BYTES,
  localparam int IDX_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_pull,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  input  logic              cfg_we,
  input  logic [SP_W-1:0]   cfg_sp,
  input  logic [BANK_W-1:0] cfg_bank,
  output logic [SP_W-1:0]   sp,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [DATA_W-1:0] pull_data,
  output logic              pull_done
);

  logic             accept;
  logic             cfg_load;
  logic             is_pull;
  logic [IDX_W-1:0] byte_idx;
  logic             wr_stb;
  logic             rd_stb;
  logic             last_byte;
  logic [ADDR_W-1:0] addr_cur;
  logic [ADDR_W-1:0] addr_next;

  assign accept   = cmd_valid && !busy;
  assign cfg_load = cfg_we && !busy;

  stkx_seq #(.SIZE_W(SIZE_W), .MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_pull(cmd_pull),
    .cmd_size(cmd_size), .busy(busy), .is_pull(is_pull), .byte_idx(byte_idx),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .last_byte(last_byte), .done(pull_done)
  );

  stkx_ptr_regs #(.SP_W(SP_W), .BANK_W(BANK_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sp(cfg_sp),
    .cfg_bank(cfg_bank), .step_dn(wr_stb), .step_up(rd_stb), .busy(busy),
    .sp_q(sp), .bank_q(bank), .addr_cur(addr_cur), .addr_next(addr_next)
  );

  stkx_pack #(.MAX_BYTES(MAX_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_pull(cmd_pull),
    .cmd_data(cmd_data), .byte_idx(byte_idx), .rd_stb(rd_stb),
    .last_byte(last_byte), .rd_byte(mem_rdata), .wr_byte(mem_wdata),
    .result(pull_data)
  );

  // A pull reads at the raised pointer; a push writes at the current one.
  assign mem_addr = is_pull ? addr_next : addr_cur;
  assign mem_we   = wr_stb;
  assign mem_re   = rd_stb;

  // R3: after each write the pointer is one below the address just written
  assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == SP_W'($past(mem_addr[SP_W-1:0]) - 1'b1));

  // R4: after each read the pointer equals the address just read
  assert_pull_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp == $past(mem_addr[SP_W-1:0]));

  // R1: the upper address field always carries the bank
  assert_bank_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> mem_addr[ADDR_W-1:SP_W] == bank);

  // R7: strobes only while busy, never both at once
  assert_strobe_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}) && ((mem_we || mem_re) == busy));

  // R5: the result is announced only once the engine is idle again
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pull_done |-> !busy);

endmodule

// File: tb/stack_xfer_engine_tb.sv
module stack_xfer_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_pull = 0;
  logic [7:0]  cmd_size = 0;
  logic [63:0] cmd_data = 0;
  logic        busy;
  logic        cfg_we = 0;
  logic [15:0] cfg_sp = 0;
  logic [7:0]  cfg_bank = 0;
  logic [15:0] sp;
  logic [7:0]  bank;
  logic [23:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [63:0] pull_data;
  logic        pull_done;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  mem [0:4095];
  logic [31:0] log_q [$];   // {we, addr[22:0]...} stored as {addr24, data8}
  int busy_cycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pull(cmd_pull),
    .cmd_size(cmd_size), .cmd_data(cmd_data), .busy(busy), .cfg_we(cfg_we),
    .cfg_sp(cfg_sp), .cfg_bank(cfg_bank), .sp(sp), .bank(bank),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pull_data(pull_data),
    .pull_done(pull_done)
  );

  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      log_q.push_back({mem_addr, mem_wdata});
    end else if (mem_re) begin
      log_q.push_back({mem_addr, mem_rdata});
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [15:0] p, input logic [7:0] b);
    @(negedge clk);
    cfg_we = 1; cfg_sp = p; cfg_bank = b;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Issues one command and waits for busy to fall; ends on a negedge
  // in the cycle right after the last byte.
  task automatic run_cmd(input logic pull, input logic [63:0] d, input logic [7:0] sz);
    log_q.delete();
    @(negedge clk);
    cmd_valid = 1; cmd_pull = pull; cmd_data = d; cmd_size = sz;
    @(negedge clk);
    cmd_valid = 0;
    busy_cycles = 0;
    for (int i = 0; i < 40 && busy; i++) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  function automatic int model_count(input int s);
    return (s <= 1) ? 1 : (s >= 8 ? 8 : s);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    check("R7", "busy after reset", 64'(busy), 0);
    check("R8", "sp after reset", 64'(sp), 0);
    check("R6", "bank after reset", 64'(bank), 0);
    check("R5", "pull_done after reset", 64'(pull_done), 0);
    check("R7", "no strobes idle", 64'({mem_we, mem_re}), 0);
  endtask

  task automatic t_cfg_load_r8;
    do_cfg(16'h0010, 8'h3A);
    check("R8", "sp loaded", 64'(sp), 64'h0010);
    check("R8", "bank loaded", 64'(bank), 64'h3A);
  endtask

  // Push: bytes go out high first at descending addresses.
  task automatic t_push(input logic [63:0] d, input int sz, input string tag);
    logic [15:0] p0 = sp;
    logic [7:0]  b0 = bank;
    int n = model_count(sz);
    run_cmd(0, d, 8'(sz));
    check("R7", {tag, " busy cycles"}, 64'(busy_cycles), 64'(n));
    check("R2", {tag, " byte count"}, 64'(log_q.size()), 64'(n));
    for (int k = 0; k < n && k < log_q.size(); k++) begin
      check("R1", {tag, " write address"}, 64'(log_q[k][31:8]),
            64'({b0, 16'(p0 - 16'(k))}));
      check("R3", {tag, " write byte"}, 64'(log_q[k][7:0]), 64'(d[(n-1-k)*8 +: 8]));
    end
    check("R3", {tag, " sp after push"}, 64'(sp), 64'(16'(p0 - 16'(n))));
    check("R6", {tag, " bank kept"}, 64'(bank), 64'(b0));
  endtask

  // Pull: pointer raised first, result filled low byte first, upper zero.
  task automatic t_pull(input int sz, input string tag);
    logic [15:0] p0 = sp;
    logic [7:0]  b0 = bank;
    int n = model_count(sz);
    logic [63:0] exp = '0;
    for (int k = 0; k < n; k++) exp[k*8 +: 8] = mem[12'(p0 + 16'(k + 1))];
    run_cmd(1, 64'hDEAD_BEEF_DEAD_BEEF, 8'(sz));
    check("R7", {tag, " busy cycles"}, 64'(busy_cycles), 64'(n));
    check("R5", {tag, " done strobe"}, 64'(pull_done), 1);
    check("R4", {tag, " first read address"}, 64'(log_q[0][31:8]),
          64'({b0, 16'(p0 + 16'd1)}));
    check("R5", {tag, " pulled value"}, pull_data, exp);
    check("R4", {tag, " sp after pull"}, 64'(sp), 64'(16'(p0 + 16'(n))));
    @(negedge clk);
    check("R5", {tag, " done one cycle"}, 64'(pull_done), 0);
    check("R5", {tag, " value held"}, pull_data, exp);
  endtask

  task automatic t_wrap_r6;
    do_cfg(16'h0001, 8'h5C);
    t_push(64'h0000_0000_A1B2_C3D4, 4, "wrap push R6");
    check("R6", "sp wrapped down", 64'(sp), 64'hFFFD);
    t_pull(4, "wrap pull R6");
    check("R6", "sp wrapped up", 64'(sp), 64'h0001);
    check("R6", "wrap pull data", pull_data, 64'h0000_0000_A1B2_C3D4);
  endtask

  task automatic t_busy_ignore_r7_r8;
    do_cfg(16'h0100, 8'h21);
    log_q.delete();
    @(negedge clk);
    cmd_valid = 1; cmd_pull = 0; cmd_data = 64'h11223344; cmd_size = 4;
    @(negedge clk);
    cmd_size = 8; cmd_data = '1;           // still offered while busy
    cfg_we = 1; cfg_sp = 16'h5555; cfg_bank = 8'h77;
    @(negedge clk);
    cmd_valid = 0; cfg_we = 0;
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    check("R7", "command while busy ignored (byte count)", 64'(log_q.size()), 4);
    check("R8", "cfg while busy ignored (sp)", 64'(sp), 64'h00FC);
    check("R8", "cfg while busy ignored (bank)", 64'(bank), 64'h21);
    check("R3", "first byte of size 4", 64'(log_q[0][7:0]), 64'h11);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cfg_load_r8();
    t_push(64'h0102_0304_0506_0708, 8, "push8 R2");
    t_pull(8, "pull8 R4");
    check("R4", "round trip", pull_data, 64'h0102_0304_0506_0708);
    t_push(64'hFFFF_FFFF_FFFF_FF5A, 0, "size0 R2");
    t_push(64'hFFFF_FFFF_FFFF_FF6B, 1, "size1 R2");
    t_push(64'h0000_0000_0099_8877, 3, "size3 R2");
    t_push(64'hCAFE_F00D_1234_5678, 200, "size200 R2");
    t_pull(3, "pull3 R5");
    t_pull(0, "pull0 R5");
    t_wrap_r6();
    t_busy_ignore_r7_r8();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule